// File: doc/BRIEF.md
# CPU Standby Mode Controller

This block decides when the clock of a small 8-bit CPU core runs and when it is held off. Two standby states are supported. The light one is entered from a decoded wait-instruction strobe. The deep one is entered from a decoded stop-instruction strobe. Entering either state clears the core's interrupt-mask bit, so the request that ends the standby period can be taken.

In the light state, any interrupt request wakes the core, whether it comes from an internal peripheral or from an external pin. The core clock then runs again on the next cycle. In the deep state, only external requests are seen. Such a request starts a stabilization period, which stands in for the oscillator start-up. The period is counted in oscillator cycles, marked by a tick input. The core clock comes back only after the full count.

A synchronous reset overrides everything. It returns the block to the run state with the clock enabled and the mask bit set. A leave caused by an interrupt keeps the mask clear. A two-bit status output reports the current state to the surrounding logic. A separate flag tells the clock generator that the deep state is active.

Top module: `standby_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, the next cycle shows status 2'b00 (run), `cpu_clk_en` 1, `i_mask` 1 and `stop_o` 0.
- R2: In run, a `wait_op` pulse without `stop_op` gives status 2'b01 (wait), `cpu_clk_en` 0 and `i_mask` 0 on the next cycle.
- R3: In run, a `stop_op` pulse gives status 2'b10 (stop), `cpu_clk_en` 0, `i_mask` 0 and `stop_o` 1 on the next cycle. It also wins when `wait_op` is high in the same cycle.
- R4: In wait, any bit of `int_irq` or `ext_irq` gives status run with `cpu_clk_en` 1 on the next cycle, and `i_mask` stays 0.
- R5: In stop, requests on `int_irq` alone are ignored: status stays 2'b10 and `cpu_clk_en` stays 0.
- R6: In stop, any bit of `ext_irq` gives status 2'b11 (stabilizing) on the next cycle, with `cpu_clk_en` 0 and `stop_o` 0.
- R7: In stabilizing, the block returns to run with `cpu_clk_en` 1 and `i_mask` 0 right after the `STAB_CYCLES`-th clock edge at which `osc_tick` is high. Edges with `osc_tick` low are not counted. The count starts from zero on every stop entry.
- R8: A reset during wait, stop or stabilizing returns the block to run with `i_mask` 1, even while interrupt requests are active. `i_mask` never goes from 0 to 1 except through reset.
- R9: The `wait_op` and `stop_op` strobes have no effect outside run, and interrupt requests have no effect in run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wait_op | input | 1 | Decoded wait-instruction strobe |
| stop_op | input | 1 | Decoded stop-instruction strobe |
| int_irq | input | N_INT | Internal peripheral interrupt requests |
| ext_irq | input | N_EXT | External interrupt requests |
| osc_tick | input | 1 | One pulse per stable oscillator cycle |
| cpu_clk_en | output | 1 | Core clock enable |
| i_mask | output | 1 | Interrupt-mask bit of the condition code register |
| stop_o | output | 1 | Deep standby indication for the clock generator |
| state_o | output | 2 | Status: 00 run, 01 wait, 10 stop, 11 stabilizing |

## Verification
Some behaviours are checked by assertions on every cycle:
- each entry transition;
- a wait wake-up from either source;
- holding in stop while no external request is present;
- holding in stabilizing on edges without a tick;
- the rule that the mask bit can only rise through reset.

A tick counter in the checker also confirms that the stabilizing state ends exactly on the last counted tick. Other properties need the bench's scenarios:
- the exact length of the delay under a gappy tick pattern;
- reset priority over active requests;
- the clearing of the count on a fresh stop entry.

A behavioural reference model compares all outputs on every clock.

// File: rtl/standby_pkg.sv
// Shared types for the standby mode controller.
// Assumes: the status encoding is visible at the top ports and must stay fixed.
package standby_pkg;
    typedef enum logic [1:0] {
        ST_RUN  = 2'b00,
        ST_WAIT = 2'b01,
        ST_STOP = 2'b10,
        ST_STAB = 2'b11
    } sb_state_t;
endpackage

// File: rtl/sb_req_merge.sv
// Reduces a vector of interrupt requests to a single "any request" flag.
// Assumes: requests are already qualified by their source enables.
module sb_req_merge #(
    parameter int W = 4
) (
    input  logic [W-1:0] req,
    output logic         any_req
);
    generate
        if (W == 1) begin : g_single
            // Single source: pass straight through.
            assign any_req = req[0];
        end else begin : g_multi
            // Several sources: OR reduction.
            assign any_req = |req;
        end
    endgenerate
endmodule

// File: rtl/sb_stab_timer.sv
// Counts oscillator ticks during the stabilizing state and flags the last one.
// Assumes: clear is pulsed on every stop entry and on every stop wake-up.
module sb_stab_timer #(
    parameter int STAB_CYCLES = 4096
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic count_en,
    output logic done
);
    localparam int CW = $clog2(STAB_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(STAB_CYCLES - 1);

    logic [CW-1:0] cnt;

    // Tick counter, cleared on request or on reset.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt <= '0;
        end else if (count_en && cnt != LAST) begin
            cnt <= cnt + 1'b1;
        end
    end

    // Done when the final tick arrives.
    assign done = count_en && (cnt == LAST);
endmodule

// File: rtl/sb_fsm.sv
// State machine for run / wait / stop / stabilizing and the interrupt-mask bit.
// Assumes: stop strobe beats wait strobe; reset is synchronous and overrides all.
module sb_fsm
    import standby_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      wait_op,
    input  logic      stop_op,
    input  logic      any_int,
    input  logic      any_ext,
    input  logic      osc_tick,
    input  logic      stab_done,
    output logic      stab_clear,
    output logic      stab_count,
    output sb_state_t state,
    output logic      mask
);
    sb_state_t nxt;

    // Next-state selection.
    always_comb begin
        nxt = state;
        unique case (state)
            ST_RUN:  if (stop_op) nxt = ST_STOP;
                     else if (wait_op) nxt = ST_WAIT;
            ST_WAIT: if (any_int || any_ext) nxt = ST_RUN;
            ST_STOP: if (any_ext) nxt = ST_STAB;
            ST_STAB: if (stab_done) nxt = ST_RUN;
            default: nxt = ST_RUN;
        endcase
    end

    // Timer control: clear on stop entry and on wake-up, count ticks while stabilizing.
    assign stab_clear = (state == ST_RUN && stop_op) || (state == ST_STOP && any_ext);
    assign stab_count = (state == ST_STAB) && osc_tick;

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_RUN;
        else        state <= nxt;
    end

    // Mask bit: set by reset, cleared on any standby entry, otherwise held.
    always_ff @(posedge clk) begin
        if (!rst_n)                                   mask <= 1'b1;
        else if (state == ST_RUN && (stop_op || wait_op)) mask <= 1'b0;
    end
endmodule

// File: rtl/standby_ctrl.sv
// Top of the CPU standby controller: merges requests, runs the FSM and timer,
// and derives the clock enable and the stop flag from the registered state.
// Assumes: osc_tick marks oscillator cycles once the oscillator runs again.
module standby_ctrl
    import standby_pkg::*;
#(
    parameter int N_INT       = 4,
    parameter int N_EXT       = 2,
    parameter int STAB_CYCLES = 4096
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wait_op,
    input  logic             stop_op,
    input  logic [N_INT-1:0] int_irq,
    input  logic [N_EXT-1:0] ext_irq,
    input  logic             osc_tick,
    output logic             cpu_clk_en,
    output logic             i_mask,
    output logic             stop_o,
    output logic [1:0]       state_o
);
    logic      any_int, any_ext;
    logic      stab_clear, stab_count, stab_done;
    sb_state_t state;

    sb_req_merge #(.W(N_INT)) u_int_merge (.req(int_irq), .any_req(any_int));
    sb_req_merge #(.W(N_EXT)) u_ext_merge (.req(ext_irq), .any_req(any_ext));

    sb_stab_timer #(.STAB_CYCLES(STAB_CYCLES)) u_timer (
        .clk(clk), .rst_n(rst_n), .clear(stab_clear),
        .count_en(stab_count), .done(stab_done)
    );

    sb_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .wait_op(wait_op), .stop_op(stop_op),
        .any_int(any_int), .any_ext(any_ext), .osc_tick(osc_tick),
        .stab_done(stab_done), .stab_clear(stab_clear), .stab_count(stab_count),
        .state(state), .mask(i_mask)
    );

    // Output decode from the registered state.
    assign cpu_clk_en = (state == ST_RUN);
    assign stop_o     = (state == ST_STOP);
    assign state_o    = state;
endmodule

// File: rtl/standby_ctrl_chk.sv
// Assertion checker bound to standby_ctrl; observes ports only.
// Assumes: the status encoding 00 run, 01 wait, 10 stop, 11 stabilizing.
module standby_ctrl_chk #(
    parameter int N_INT       = 4,
    parameter int N_EXT       = 2,
    parameter int STAB_CYCLES = 4096
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wait_op,
    input logic             stop_op,
    input logic [N_INT-1:0] int_irq,
    input logic [N_EXT-1:0] ext_irq,
    input logic             osc_tick,
    input logic             cpu_clk_en,
    input logic             i_mask,
    input logic             stop_o,
    input logic [1:0]       state_o
);
    int ticks;

    // Independent count of ticks seen while stabilizing.
    always_ff @(posedge clk) begin
        if (!rst_n || state_o != 2'b11) ticks <= 0;
        else if (osc_tick)              ticks <= ticks + 1;
    end

    p_wait_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 2'b00 && wait_op && !stop_op) |=> (state_o == 2'b01 && !cpu_clk_en && !i_mask));

    p_stop_entry_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 2'b00 && stop_op) |=> (state_o == 2'b10 && stop_o && !i_mask && !cpu_clk_en));

    p_wait_wake_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 2'b01 && ((|int_irq) || (|ext_irq))) |=> (state_o == 2'b00 && cpu_clk_en && !i_mask));

    p_stop_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 2'b10 && !(|ext_irq)) |=> (state_o == 2'b10 && !cpu_clk_en));

    p_stop_wake_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 2'b10 && (|ext_irq)) |=> (state_o == 2'b11 && !cpu_clk_en && !stop_o));

    p_stab_notick_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 2'b11 && !osc_tick) |=> (state_o == 2'b11));

    p_stab_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 2'b11 && osc_tick && ticks == STAB_CYCLES - 1) |=> (state_o == 2'b00 && cpu_clk_en));

    p_stab_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 2'b11) |-> (ticks < STAB_CYCLES));

    p_mask_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(i_mask) |-> $past(!rst_n));

    p_run_irq_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 2'b00 && !wait_op && !stop_op) |=> (state_o == 2'b00 && $stable(i_mask)));
endmodule

bind standby_ctrl standby_ctrl_chk #(
    .N_INT(N_INT), .N_EXT(N_EXT), .STAB_CYCLES(STAB_CYCLES)
) u_chk (
    .clk(clk), .rst_n(rst_n), .wait_op(wait_op), .stop_op(stop_op),
    .int_irq(int_irq), .ext_irq(ext_irq), .osc_tick(osc_tick),
    .cpu_clk_en(cpu_clk_en), .i_mask(i_mask), .stop_o(stop_o), .state_o(state_o)
);

// File: tb/tb_standby_ctrl.sv
// Self-checking bench with a behavioural reference model compared on every clock.
module tb_standby_ctrl;
    localparam int N_INT = 4;
    localparam int N_EXT = 2;
    localparam int STAB  = 40;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             wait_op = 1'b0;
    logic             stop_op = 1'b0;
    logic [N_INT-1:0] int_irq = '0;
    logic [N_EXT-1:0] ext_irq = '0;
    logic             osc_tick = 1'b0;
    logic             cpu_clk_en, i_mask, stop_o;
    logic [1:0]       state_o;

    int    n_checks = 0;
    int    n_fails  = 0;
    string cur_req  = "R1";
    bit    cmp_on   = 1'b0;

    // Reference model state.
    int m_state = 0;
    int m_mask  = 1;
    int m_cnt   = 0;

    always #5 clk = ~clk;

    standby_ctrl #(.N_INT(N_INT), .N_EXT(N_EXT), .STAB_CYCLES(STAB)) dut (
        .clk(clk), .rst_n(rst_n), .wait_op(wait_op), .stop_op(stop_op),
        .int_irq(int_irq), .ext_irq(ext_irq), .osc_tick(osc_tick),
        .cpu_clk_en(cpu_clk_en), .i_mask(i_mask), .stop_o(stop_o), .state_o(state_o)
    );

    // Behavioural model of the requirements.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_state = 0; m_mask = 1; m_cnt = 0;
        end else begin
            case (m_state)
                0: if (stop_op) begin m_state = 2; m_mask = 0; m_cnt = 0; end
                   else if (wait_op) begin m_state = 1; m_mask = 0; end
                1: if (int_irq != 0 || ext_irq != 0) m_state = 0;
                2: if (ext_irq != 0) begin m_state = 3; m_cnt = 0; end
                default: if (osc_tick) begin
                    m_cnt = m_cnt + 1;
                    if (m_cnt == STAB) m_state = 0;
                end
            endcase
        end
    end

    task automatic chk(input string req, input int act, input int exp, input string what);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // Compare against the model away from the active edge.
    always @(negedge clk) begin
        if (cmp_on) begin
            chk(cur_req, int'(state_o), m_state, "model state");
            chk(cur_req, int'(i_mask), m_mask, "model mask");
            chk(cur_req, int'(cpu_clk_en), (m_state == 0) ? 1 : 0, "model clk_en");
            chk(cur_req, int'(stop_o), (m_state == 2) ? 1 : 0, "model stop");
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; cyc(2); rst_n = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

    initial begin
        cyc(1);
        cmp_on = 1'b1;
        // R1: reset state
        cur_req = "R1";
        cyc(2);
        chk("R1", int'(state_o), 0, "reset state");
        chk("R1", int'(i_mask), 1, "reset mask");
        chk("R1", int'(cpu_clk_en), 1, "reset clk_en");
        rst_n = 1'b1;
        cyc(1);

        // R9: requests in run do nothing
        cur_req = "R9";
        int_irq = 4'b0101; ext_irq = 2'b01; cyc(2);
        int_irq = '0; ext_irq = '0; cyc(1);
        chk("R9", int'(state_o), 0, "irq in run");

        // R2: wait entry
        cur_req = "R2";
        wait_op = 1'b1; cyc(1); wait_op = 1'b0;
        chk("R2", int'(state_o), 1, "wait state");
        chk("R2", int'(i_mask), 0, "wait mask");
        chk("R2", int'(cpu_clk_en), 0, "wait clk_en");
        // R9: strobes in wait ignored
        cur_req = "R9";
        stop_op = 1'b1; wait_op = 1'b1; cyc(1); stop_op = 1'b0; wait_op = 1'b0;
        chk("R9", int'(state_o), 1, "strobes in wait");
        cyc(3);
        // R4: internal request wakes
        cur_req = "R4";
        int_irq = 4'b1000; cyc(1); int_irq = '0;
        chk("R4", int'(state_o), 0, "int wake state");
        chk("R4", int'(cpu_clk_en), 1, "int wake clk_en");
        chk("R4", int'(i_mask), 0, "int wake mask");
        // R4: external request wakes
        wait_op = 1'b1; cyc(1); wait_op = 1'b0; cyc(2);
        ext_irq = 2'b10; cyc(1); ext_irq = '0;
        chk("R4", int'(state_o), 0, "ext wake state");

        // R3: stop wins over wait
        cur_req = "R3";
        stop_op = 1'b1; wait_op = 1'b1; cyc(1); stop_op = 1'b0; wait_op = 1'b0;
        chk("R3", int'(state_o), 2, "stop state");
        chk("R3", int'(stop_o), 1, "stop flag");
        chk("R3", int'(i_mask), 0, "stop mask");
        // R5: internal requests ignored in stop
        cur_req = "R5";
        int_irq = 4'b1111; osc_tick = 1'b1; wait_op = 1'b1; cyc(6);
        int_irq = '0; wait_op = 1'b0;
        chk("R5", int'(state_o), 2, "int in stop");
        chk("R5", int'(cpu_clk_en), 0, "clk off in stop");
        osc_tick = 1'b0;
        // R6: external request leaves stop
        cur_req = "R6";
        ext_irq = 2'b01; cyc(1); ext_irq = '0;
        chk("R6", int'(state_o), 3, "stab state");
        chk("R6", int'(stop_o), 0, "stop flag off");
        // R7: exact tick count with gaps
        cur_req = "R7";
        for (int i = 1; i <= STAB; i++) begin
            osc_tick = 1'b1; cyc(1); osc_tick = 1'b0;
            chk("R7", int'(state_o), (i == STAB) ? 0 : 3, "stab progress");
            cyc(1);
        end
        chk("R7", int'(cpu_clk_en), 1, "clk back");
        chk("R7", int'(i_mask), 0, "mask after stab");

        // R7: count restarts on a fresh stop entry
        stop_op = 1'b1; cyc(1); stop_op = 1'b0;
        ext_irq = 2'b11; cyc(1); ext_irq = '0;
        osc_tick = 1'b1; cyc(STAB - 1);
        chk("R7", int'(state_o), 3, "one tick short");
        cyc(1); osc_tick = 1'b0;
        chk("R7", int'(state_o), 0, "second stab done");

        // R8: reset during stop with active request
        cur_req = "R8";
        stop_op = 1'b1; cyc(1); stop_op = 1'b0;
        ext_irq = 2'b01; rst_n = 1'b0; cyc(1); rst_n = 1'b1; ext_irq = '0;
        chk("R8", int'(state_o), 0, "reset in stop");
        chk("R8", int'(i_mask), 1, "reset mask");
        // R8: reset during stabilizing
        stop_op = 1'b1; cyc(1); stop_op = 1'b0;
        ext_irq = 2'b10; cyc(1); ext_irq = '0;
        osc_tick = 1'b1; cyc(5); osc_tick = 1'b0;
        int_irq = 4'b0010; do_reset(); int_irq = '0;
        chk("R8", int'(state_o), 0, "reset in stab");
        chk("R8", int'(i_mask), 1, "reset mask stab");
        // R8: reset during wait with request
        wait_op = 1'b1; cyc(1); wait_op = 1'b0;
        int_irq = 4'b0001; rst_n = 1'b0; cyc(1); rst_n = 1'b1; int_irq = '0;
        chk("R8", int'(i_mask), 1, "reset in wait");
        cyc(3);

        cmp_on = 1'b0;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end
endmodule